// File: doc/BRIEF.md
# IO Interrupt Redirection Controller

The block takes a set of interrupt request lines (24 by default) and turns each active line into an interrupt message. Each line has its own redirection entry, which gives the vector, delivery mode, destination mode, trigger mode and mask, plus a separate destination byte. Software reaches all entries through two 32-bit words on a small memory-mapped port. The word at offset 0x00 selects a register number. The word at offset 0x10 is a window onto the register that number selects.

Each line has a pending bit, which is set when the line rises. For level-triggered lines, a remote-IRR interlock lets only one message out until an end-of-interrupt (EOI) arrives. The EOI carries the serviced vector on a separate input. Messages leave on a valid/ready handshake. When several lines are ready together, the lowest-numbered line goes first.

Top module: `irq_redirector`

## Requirements
- R1: A write at offset 0x00 loads the register number (bits 7:0), and a read at 0x00 returns it. Window reads and writes at 0x10 act on the selected register. Other offsets, register numbers 3 to 0x0F, and numbers at or above 0x10+2·LINES read as zero, and writes to them are ignored.
- R2: Register 0 holds a 4-bit ID in bits 27:24; a write keeps only those bits. Register 2 returns the same ID. Register 1 reads 0x11 in bits 7:0 and LINES-1 in bits 23:16, so the default reads 0x00170011.
- R3: After reset the ID is 0, every configuration register reads 0x00010000 (masked), every destination register reads 0, and no message is offered.
- R4: The configuration register for line n is register 0x10+2n, with this layout:
  - vector in bits 7:0;
  - delivery mode in bits 10:8;
  - destination mode in bit 11;
  - delivery status in bit 12;
  - remote IRR in bit 14;
  - trigger mode in bit 15 (1 = level);
  - mask in bit 16.

  A write leaves bits 12, 14 and 31:17 unchanged. Bits 13 and 31:17 always read zero.
- R5: The destination register for line n is register 0x11+2n. Only bits 31:24 are stored; all other bits read zero.
- R6: A line becomes pending only on a low-to-high transition. An edge entry that is masked at that moment drops the event. A masked level entry keeps it pending. A level line that is low clears its pending bit.
- R7: A pending, unmasked edge entry offers a message. The accepted handshake clears the pending bit, so one rise gives one message.
- R8: The accepted handshake of a level entry sets remote IRR. No further message comes from that entry while remote IRR is set.
- R9: An EOI clears remote IRR in every entry whose vector equals the EOI vector. A level line that is still high then sends again.
- R10: A configuration write takes effect at once, so unmasking a pending line offers its message.
- R11: When several lines are ready, the lowest-numbered one is offered, one per accepted handshake. The message carries that entry's vector, delivery mode, trigger mode, destination mode and destination byte.
- R12: Delivery status reads 1 while the entry is ready to send and its message is not yet accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 select, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| irq_lines | input | LINES | Interrupt request lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger mode (1 = level) |
| msg_dest | output | 8 | Message destination byte |
| msg_logical | output | 1 | Message destination mode |

## Verification
Single rising pulses on edge lines, taken masked and unmasked, separate event capture from event loss. Held level lines are run with and without an EOI, and with a matching and a non-matching vector, which shows whether the interlock releases only on the right vector. Two lines raised together while ready is held low show the priority order and the delivery status bit. A long random run follows, with random line activity, random ready and random EOI vectors over all entries. It is compared each cycle against a behavioural model and exposes any mismatch in ordering, repeated delivery or lost events.

// File: rtl/irq_redirector.sv
module irq_redirector #(
  parameter int LINES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [LINES-1:0] irq_lines,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_mode,
  output logic             msg_level,
  output logic [7:0]       msg_dest,
  output logic             msg_logical
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int REG_END = 16 + 2 * LINES;
  localparam logic [7:0] MAX_ENTRY = 8'(LINES - 1);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic [LINES-1:0] irq_q, pend_q, mask_q, lvl_q, logi_q, rirr_q;
  logic [7:0]       vec_q  [LINES];
  logic [2:0]       mode_q [LINES];
  logic [7:0]       dest_q [LINES];

  logic [LINES-1:0] cand, rise;
  logic [LW-1:0]    pick, ent;
  logic [7:0]       rel;
  logic [31:0]      rd_reg;
  logic             win_wr, in_table, hs;
  logic             unused_bits;

  assign win_wr   = bus_en & bus_we & (bus_addr == 8'h10);
  assign in_table = (sel_q >= 8'h10) && (int'(sel_q) < REG_END);
  assign rel      = sel_q - 8'h10;
  assign ent      = LW'(rel[7:1]);
  assign unused_bits = ^{bus_wdata[23:17], bus_wdata[14:12], rel[0]};

  assign rise = irq_lines & ~irq_q;
  assign cand = pend_q & ~mask_q & ~(lvl_q & rirr_q);

  always_comb begin
    pick = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (cand[i]) pick = LW'(i);
  end

  assign msg_valid   = |cand;
  assign msg_vector  = vec_q[pick];
  assign msg_mode    = mode_q[pick];
  assign msg_level   = lvl_q[pick];
  assign msg_dest    = dest_q[pick];
  assign msg_logical = logi_q[pick];
  assign hs          = msg_valid & msg_ready;

  always_comb begin
    rd_reg = '0;
    if (sel_q == 8'd0 || sel_q == 8'd2)
      rd_reg = {4'b0, id_q, 24'b0};
    else if (sel_q == 8'd1)
      rd_reg = {8'h00, MAX_ENTRY, 8'h00, 8'h11};
    else if (in_table) begin
      if (sel_q[0])
        rd_reg = {dest_q[ent], 24'b0};
      else
        rd_reg = {15'b0, mask_q[ent], lvl_q[ent], rirr_q[ent], 1'b0,
                  cand[ent], logi_q[ent], mode_q[ent], vec_q[ent]};
    end
  end

  assign bus_rdata = (!bus_en || bus_we) ? 32'b0 :
                     (bus_addr == 8'h00) ? {24'b0, sel_q} :
                     (bus_addr == 8'h10) ? rd_reg : 32'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      irq_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
      lvl_q  <= '0;
      logi_q <= '0;
      rirr_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        vec_q[i]  <= '0;
        mode_q[i] <= '0;
        dest_q[i] <= '0;
      end
    end else begin
      irq_q <= irq_lines;
      if (bus_en && bus_we && bus_addr == 8'h00) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == 8'd0) id_q <= bus_wdata[27:24];
      for (int i = 0; i < LINES; i++) begin
        if (hs && int'(pick) == i && !lvl_q[i]) pend_q[i] <= 1'b0;
        if (lvl_q[i] && !irq_lines[i]) pend_q[i] <= 1'b0;
        if (rise[i] && (lvl_q[i] || !mask_q[i])) pend_q[i] <= 1'b1;
        if (hs && int'(pick) == i && lvl_q[i]) rirr_q[i] <= 1'b1;
        else if (eoi_valid && rirr_q[i] && vec_q[i] == eoi_vector) rirr_q[i] <= 1'b0;
        if (win_wr && in_table && int'(ent) == i) begin
          if (sel_q[0]) dest_q[i] <= bus_wdata[31:24];
          else begin
            vec_q[i]  <= bus_wdata[7:0];
            mode_q[i] <= bus_wdata[10:8];
            logi_q[i] <= bus_wdata[11];
            lvl_q[i]  <= bus_wdata[15];
            mask_q[i] <= bus_wdata[16];
          end
        end
      end
    end
  end

  a_r3_masked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q && !msg_valid));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    a_r6_masked_edge_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[g] && !lvl_q[g] && mask_q[g] && rise[g]) |=> !pend_q[g]);
    a_r7_edge_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && int'(pick) == g && !lvl_q[g] && !rise[g]) |=> !pend_q[g]);
    a_r8_level_taken_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && int'(pick) == g && lvl_q[g]) |=> rirr_q[g]);
    a_r9_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && rirr_q[g] && vec_q[g] == eoi_vector) |=> !rirr_q[g]);
  end
endmodule

// File: tb/irq_redirector_bench.sv
module irq_redirector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 24;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [L-1:0] irq = 0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = 0;
  logic msg_valid, msg_ready = 0, msg_level, msg_logical;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirector #(.LINES(L)) u_irq_redirector (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_level(msg_level),
    .msg_dest(msg_dest), .msg_logical(msg_logical));

  // behavioural reference model
  int m_idx, m_id;
  int m_vec[L], m_mode[L], m_dest[L];
  bit m_log[L], m_lvl[L], m_mask[L], m_rirr[L], m_pend[L], m_prev[L];

  function automatic int m_pick();
    for (int i = 0; i < L; i++)
      if (m_pend[i] && !m_mask[i] && !(m_lvl[i] && m_rirr[i])) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_id = 0;
      for (int i = 0; i < L; i++) begin
        m_vec[i] = 0; m_mode[i] = 0; m_dest[i] = 0; m_log[i] = 0; m_lvl[i] = 0;
        m_mask[i] = 1; m_rirr[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
      end
    end else begin
      int s;
      s = m_pick();
      for (int i = 0; i < L; i++) begin
        bit took;
        bit eh;
        took = msg_ready && s == i;
        eh = eoi_valid && m_rirr[i] && m_vec[i] == int'(eoi_vector);
        if (took && !m_lvl[i]) m_pend[i] = 0;
        if (m_lvl[i] && !irq[i]) m_pend[i] = 0;
        if (irq[i] && !m_prev[i] && (m_lvl[i] || !m_mask[i])) m_pend[i] = 1;
        if (took && m_lvl[i]) m_rirr[i] = 1;
        else if (eh) m_rirr[i] = 0;
        m_prev[i] = irq[i];
      end
      if (bus_en && bus_we) begin
        if (bus_addr == 8'h00) m_idx = int'(bus_wdata[7:0]);
        else if (bus_addr == 8'h10) begin
          if (m_idx == 0) m_id = int'(bus_wdata[27:24]);
          else if (m_idx >= 16 && m_idx < 16 + 2*L) begin
            int n;
            n = (m_idx - 16) / 2;
            if (m_idx % 2 == 1) m_dest[n] = int'(bus_wdata[31:24]);
            else begin
              m_vec[n] = int'(bus_wdata[7:0]); m_mode[n] = int'(bus_wdata[10:8]);
              m_log[n] = bus_wdata[11]; m_lvl[n] = bus_wdata[15]; m_mask[n] = bus_wdata[16];
            end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R11: message compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int s;
      logic [31:0] a, e;
      s = m_pick();
      a = msg_valid ? {10'b0, 1'b1, msg_vector, msg_mode, msg_level, msg_dest, msg_logical} : 32'b0;
      e = (s < 0) ? 32'b0 : {10'b0, 1'b1, 8'(m_vec[s]), 3'(m_mode[s]), m_lvl[s], 8'(m_dest[s]), m_log[s]};
      chk("R11 model message", a, e);
    end
  end

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, {24'b0, idx});
    wr(8'h10, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'b0, idx});
    rd(8'h10, d);
  endtask

  task automatic take();
    msg_ready = 1; @(negedge clk); msg_ready = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1; eoi_vector = v; @(negedge clk); eoi_valid = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk("R3 no message after reset", {31'b0, msg_valid}, 32'd0);
    rreg(8'h10, d); chk("R3 entry0 config", d, 32'h00010000);
    rreg(8'h3E, d); chk("R3 entry23 config", d, 32'h00010000);
    rreg(8'h11, d); chk("R3 entry0 dest", d, 32'h0);
    rreg(8'h00, d); chk("R3 id", d, 32'h0);
    // R2 id and version
    rreg(8'h01, d); chk("R2 version", d, 32'h00170011);
    wreg(8'h00, 32'hFFFFFFFF);
    rreg(8'h00, d); chk("R2 id width", d, 32'h0F000000);
    rreg(8'h02, d); chk("R2 id mirror", d, 32'h0F000000);
    // R1 select/window and undefined space
    wr(8'h00, 32'h23); rd(8'h00, d); chk("R1 select readback", d, 32'h23);
    wr(8'h08, 32'hFFFFFFFF); rd(8'h08, d); chk("R1 other offset", d, 32'h0);
    wreg(8'h03, 32'hFFFFFFFF); rreg(8'h03, d); chk("R1 undefined reg", d, 32'h0);
    wreg(8'h40, 32'hFFFFFFFF); rreg(8'h40, d); chk("R1 beyond table", d, 32'h0);
    rreg(8'h01, d); chk("R1 version untouched", d, 32'h00170011);
    // R5 destination
    wreg(8'h11, 32'hFFFFFFFF); rreg(8'h11, d); chk("R5 dest bits", d, 32'hFF000000);
    // R7 edge delivery on line 3, R12 status
    wreg(8'h16, 32'h00000B33); wreg(8'h17, 32'h5A000000);
    irq[3] = 1; @(negedge clk); irq[3] = 0;
    chk("R7 edge offered", {msg_valid, msg_vector, msg_dest}, {1'b1, 8'h33, 8'h5A});
    rreg(8'h16, d); chk("R12 status while waiting", d, 32'h00001B33);
    take();
    chk("R7 one message per rise", {31'b0, msg_valid}, 32'd0);
    rreg(8'h16, d); chk("R12 status after accept", d, 32'h00000B33);
    // R6 masked edge dropped
    wreg(8'h18, 32'h00010044);
    irq[4] = 1; @(negedge clk); irq[4] = 0;
    wreg(8'h18, 32'h00000044);
    chk("R6 masked edge dropped", {31'b0, msg_valid}, 32'd0);
    // R8/R9 level line 5, R4 read-only merge
    wreg(8'h1A, 32'h00008045);
    irq[5] = 1; @(negedge clk);
    chk("R8 level offered", {msg_valid, msg_vector, msg_level}, {1'b1, 8'h45, 1'b1});
    take();
    chk("R8 locked after accept", {31'b0, msg_valid}, 32'd0);
    rreg(8'h1A, d); chk("R8 remote IRR set", d, 32'h0000C045);
    wreg(8'h1A, 32'hFFFE9045); rreg(8'h1A, d); chk("R4 read-only kept", d, 32'h0000C045);
    eoi(8'h46);
    chk("R9 other vector no release", {31'b0, msg_valid}, 32'd0);
    eoi(8'h45);
    chk("R9 release resends", {msg_valid, msg_vector}, {1'b1, 8'h45});
    take();
    irq[5] = 0; eoi(8'h45);
    chk("R8 deassert clears", {31'b0, msg_valid}, 32'd0);
    rreg(8'h1A, d); chk("R8 entry idle", d, 32'h00008045);
    // R10 unmask pending level on line 6
    wreg(8'h1C, 32'h00018066);
    irq[6] = 1; @(negedge clk);
    chk("R6 masked level held", {31'b0, msg_valid}, 32'd0);
    wreg(8'h1C, 32'h00008066);
    chk("R10 unmask delivers", {msg_valid, msg_vector}, {1'b1, 8'h66});
    take(); irq[6] = 0; eoi(8'h66);
    // R11 priority, R12 status on both
    wreg(8'h14, 32'h00000022); wreg(8'h1E, 32'h00000077);
    irq[2] = 1; irq[7] = 1; @(negedge clk); irq[2] = 0; irq[7] = 0;
    chk("R11 lowest first", {msg_valid, msg_vector}, {1'b1, 8'h22});
    rreg(8'h14, d); chk("R12 status line2", d, 32'h00001022);
    rreg(8'h1E, d); chk("R12 status line7", d, 32'h00001077);
    take();
    chk("R11 next line", {msg_valid, msg_vector}, {1'b1, 8'h77});
    take();
    chk("R11 drained", {31'b0, msg_valid}, 32'd0);
    // random run against the model
    for (int i = 0; i < L; i++) begin
      wreg(8'(16 + 2*i), ((i % 3 == 0) ? 32'h8000 : 32'h0) | (32'(i & 1) << 11) |
                         (32'(i % 8) << 8) | 32'(8'h20 + i));
      wreg(8'(17 + 2*i), 32'(i) << 24);
    end
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < L; i++) if ($urandom % 8 == 0) irq[i] = ~irq[i];
      msg_ready = ($urandom % 2) == 1;
      eoi_valid = ($urandom % 4) == 0;
      eoi_vector = 8'(8'h20 + $urandom % L);
      @(negedge clk);
    end
    msg_ready = 0; eoi_valid = 0;
    @(negedge clk);
    report();
  end
endmodule